// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the byte address of the instruction being fetched by a simple 32-bit RISC front end. In every cycle it works out where fetch goes next. The default is the following word. It can also be a PC-relative conditional branch target or a region-absolute jump target. The choice depends on the opcode of the current instruction word and on an equality flag from the register comparator. The register stores that next address on each clock edge while the enable input is high. It keeps its value when enable is low. A synchronous reset sends it to address zero.

The unit drives three outputs: the current address, the current address plus four (used by the link path), and the selected next address. Register reads, the comparator, the link-register write, indirect jumps and exceptions are left to neighbouring logic.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_o` becomes 32'h0000_0000 after that edge, whatever the other inputs are.
- R2: While `en` is low (and `rst` low), `pc_o` keeps its value across the clock edge.
- R3: `pc_plus4_o` always equals `pc_o + 4`. When the opcode field `instr[31:26]` is not 2, 3, 4 or 5, `pc_next_o` equals `pc_o + 4`.
- R4: Opcode 4 (branch-if-equal) with `regs_equal` = 1 gives `pc_next_o = pc_o + 4 + (sign-extended instr[15:0]) * 4`.
- R5: Opcode 4 with `regs_equal` = 0 gives `pc_next_o = pc_o + 4`.
- R6: Opcode 5 (branch-if-not-equal) is taken with the same target as R4 when `regs_equal` = 0. It falls through to `pc_o + 4` when `regs_equal` = 1.
- R7: A branch offset with bit 15 set counts as a negative number of instructions and moves the target below `pc_o + 4`.
- R8: Opcodes 2 and 3 (jump, jump-and-link) give `pc_next_o = {pc_o[31:28], instr[25:0], 2'b00}` whatever `regs_equal` is.
- R9: A jump placed at the last word of a 256 MB region (for example `pc_o` = 32'h0FFF_FFFC) takes its upper four bits from `pc_o`, not from `pc_o + 4`.
- R10: The two low bits of `pc_next_o` are always zero once reset has been applied.
- R11: The word 32'h1120_0003 with `regs_equal` = 1 targets `pc_o + 16`.
- R12: With `en` high and `rst` low, `pc_o` after a rising edge equals the `pc_next_o` shown before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable; low keeps the PC unchanged |
| instr | input | 32 | Instruction word currently fetched |
| regs_equal | input | 1 | Comparator result: the two source registers are equal |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | Current program counter plus four |
| pc_next_o | output | 32 | Address selected for the next fetch |

## Verification
The bench drives a jump whose upper address bits would come out wrong if they were taken from the incremented PC. It places this jump at the very end of a 256 MB region, where a faulty design would land in the following region. It applies a negative branch offset: a design that zero-extends it would jump far forward. It sends each branch opcode with both comparator values, which catches a swapped equal/not-equal sense. It also checks that the offset is scaled by four and added to the incremented address, using the worked example word, where a design that adds to the unincremented PC is off by one instruction. Finally it covers non-control opcodes, stalls and reset, to catch a design that does not fall through, drifts while stalled, or restarts from a non-zero address.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;

    localparam int XLEN     = 32;
    localparam int OP_W     = 6;
    localparam int IMM_W    = 16;
    localparam int TGT_W    = 26;
    localparam int ALIGN_W  = 2;

    localparam logic [OP_W-1:0] OPC_JUMP = 6'd2;
    localparam logic [OP_W-1:0] OPC_JAL  = 6'd3;
    localparam logic [OP_W-1:0] OPC_BEQ  = 6'd4;
    localparam logic [OP_W-1:0] OPC_BNE  = 6'd5;

    typedef enum logic [1:0] {
        FLOW_SEQ,
        FLOW_BR_EQ,
        FLOW_BR_NE,
        FLOW_JUMP
    } flow_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } pc_state_t;

endpackage

// File: rtl/pcnu_decode.sv
module pcnu_decode
    import pcnu_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic [OPW-1:0] opcode,
    output flow_e          flow
);

    always_comb begin
        unique case (opcode)
            OPC_BEQ:           flow = FLOW_BR_EQ;
            OPC_BNE:           flow = FLOW_BR_NE;
            OPC_JUMP, OPC_JAL: flow = FLOW_JUMP;
            default:           flow = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/pcnu_targets.sv
module pcnu_targets
    import pcnu_pkg::*;
#(
    parameter int AW   = XLEN,
    parameter int IW   = IMM_W,
    parameter int TW   = TGT_W,
    parameter int SH   = ALIGN_W
) (
    input  logic [AW-1:0] pc,
    input  logic [IW-1:0] imm,
    input  logic [TW-1:0] tgt,
    output logic [AW-1:0] seq_addr,
    output logic [AW-1:0] br_addr,
    output logic [AW-1:0] jmp_addr
);

    localparam int EXT_W    = AW - IW - SH;
    localparam int REGION_W = AW - TW - SH;
    localparam logic [AW-1:0] STEP = AW'(1) << SH;

    logic [AW-1:0] offset_bytes;

    // Sign-extend the word count and scale it to bytes.
    assign offset_bytes = {{EXT_W{imm[IW-1]}}, imm, {SH{1'b0}}};
    assign seq_addr     = pc + STEP;
    assign br_addr      = seq_addr + offset_bytes;

    generate
        if (REGION_W > 0) begin : g_region
            // Region bits come from the current PC, never the incremented one.
            assign jmp_addr = {pc[AW-1 -: REGION_W], tgt, {SH{1'b0}}};
        end else begin : g_flat
            assign jmp_addr = {tgt, {SH{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcnu_pkg::*;
#(
    parameter int AW = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [31:0]   instr,
    input  logic          regs_equal,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] pc_plus4_o,
    output logic [AW-1:0] pc_next_o
);

    localparam int OPC_LSB = 32 - OP_W;

    pc_state_t     state_d, state_q;
    flow_e         flow;
    logic [AW-1:0] seq_addr, br_addr, jmp_addr;
    logic [AW-1:0] sel_d;

    pcnu_decode #(.OPW(OP_W)) u_dec (
        .opcode (instr[31:OPC_LSB]),
        .flow   (flow)
    );

    pcnu_targets #(
        .AW (AW),
        .IW (IMM_W),
        .TW (TGT_W),
        .SH (ALIGN_W)
    ) u_tgt (
        .pc       (state_q.pc),
        .imm      (instr[IMM_W-1:0]),
        .tgt      (instr[TGT_W-1:0]),
        .seq_addr (seq_addr),
        .br_addr  (br_addr),
        .jmp_addr (jmp_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (flow)
            FLOW_BR_EQ: sel_d = regs_equal ? br_addr : seq_addr;
            FLOW_BR_NE: sel_d = regs_equal ? seq_addr : br_addr;
            FLOW_JUMP:  sel_d = jmp_addr;
            default:    sel_d = seq_addr;
        endcase
        if (rst) begin
            state_d.pc = '0;
        end else if (en) begin
            state_d.pc = sel_d;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pc_o       = state_q.pc;
    assign pc_plus4_o = seq_addr;
    assign pc_next_o  = sel_d;

endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic [31:0] instr,
    input logic        regs_equal,
    input logic [31:0] pc_o,
    input logic [31:0] pc_plus4_o,
    input logic [31:0] pc_next_o
);

    logic is_jump;
    logic is_ctrl;
    assign is_jump = (instr[31:26] == 6'd2) || (instr[31:26] == 6'd3);
    assign is_ctrl = is_jump || (instr[31:26] == 6'd4) || (instr[31:26] == 6'd5);

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (pc_o == 32'h0)); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pc_o == $past(pc_o))); // R2

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !is_ctrl |-> (pc_next_o == pc_plus4_o)); // R3

    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
        is_jump |-> (pc_next_o[31:28] == pc_o[31:28])); // R9

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        pc_next_o[1:0] == 2'b00); // R10

    AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        en |=> (pc_o == $past(pc_next_o))); // R12

endmodule

bind pc_next_unit pc_next_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .instr      (instr),
    .regs_equal (regs_equal),
    .pc_o       (pc_o),
    .pc_plus4_o (pc_plus4_o),
    .pc_next_o  (pc_next_o)
);

// File: tb/sim_pc_next_unit.sv
`timescale 1ns/1ps
module sim_pc_next_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        regs_equal = 1'b0;
    logic [31:0] pc_o, pc_plus4_o, pc_next_o;

    always #10 clk = ~clk;

    pc_next_unit u0 (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .instr      (instr),
        .regs_equal (regs_equal),
        .pc_o       (pc_o),
        .pc_plus4_o (pc_plus4_o),
        .pc_next_o  (pc_next_o)
    );

    typedef struct {
        logic        chk_pc;
        logic        chk_next;
        logic [31:0] pc;
        logic [31:0] nxt;
        string       req;
    } item_t;

    item_t       sb[$];
    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] model_pc = 32'h0;
    logic        model_valid = 1'b0;

    function automatic logic [31:0] expect_next(logic [31:0] pc, logic [31:0] iw, logic eq);
        logic [31:0] inc, tgt_br;
        inc    = pc + 32'd4;
        tgt_br = inc + {{14{iw[15]}}, iw[15:0], 2'b00};
        case (iw[31:26])
            6'd2, 6'd3: return {pc[31:28], iw[25:0], 2'b00};
            6'd4:       return eq ? tgt_br : inc;
            6'd5:       return eq ? inc : tgt_br;
            default:    return inc;
        endcase
    endfunction

    task automatic step(input logic r, input logic e, input logic [31:0] iw,
                        input logic eq, input string req);
        item_t it;
        @(negedge clk);
        rst        = r;
        en         = e;
        instr      = iw;
        regs_equal = eq;
        it.chk_pc   = model_valid;
        it.chk_next = model_valid && !r;
        it.pc       = model_pc;
        it.nxt      = expect_next(model_pc, iw, eq);
        it.req      = req;
        sb.push_back(it);
        if (r) begin
            model_pc    = 32'h0;
            model_valid = 1'b1;
        end else if (e) begin
            model_pc = it.nxt;
        end
    endtask

    // Monitor: compares outputs a little after each driving edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                if (it.chk_pc) begin
                    n_vec++;
                    if (pc_o !== it.pc) begin
                        n_bad++;
                        $display("FAIL %s pc_o actual=%h expected=%h", it.req, pc_o, it.pc);
                    end
                end
                if (it.chk_next) begin
                    n_vec += 2;
                    if (pc_next_o !== it.nxt) begin
                        n_bad++;
                        $display("FAIL %s pc_next_o actual=%h expected=%h", it.req, pc_next_o, it.nxt);
                    end
                    if (pc_plus4_o !== it.pc + 32'd4) begin
                        n_bad++;
                        $display("FAIL R3 pc_plus4_o actual=%h expected=%h", pc_plus4_o, it.pc + 32'd4);
                    end
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        step(1, 0, 32'h0, 0, "R1");
        step(1, 1, 32'h0800_1234, 1, "R1");                  // R1 reset wins over enable
        step(0, 1, 32'h0000_0020, 0, "R3");                  // R3 opcode 0
        step(0, 1, 32'h8C00_0000, 1, "R3");                  // R3 opcode 0x23
        step(0, 0, 32'h0800_0100, 0, "R2");                  // R2 stall
        step(0, 0, 32'h1000_0005, 1, "R2");                  // R2 still held
        step(0, 1, 32'h1120_0003, 1, "R11");                 // R11 example word, R4
        step(0, 1, 32'h1000_0007, 0, "R5");                  // R5 beq not taken
        step(0, 1, 32'h1400_0002, 0, "R6");                  // R6 bne taken
        step(0, 1, 32'h1400_0002, 1, "R6");                  // R6 bne not taken
        step(0, 1, 32'h1000_FFFD, 1, "R7");                  // R7 negative offset
        step(0, 1, 32'h1000_0004, 1, "R4");                  // R4 forward
        step(0, 1, 32'h0BFF_FFFF, 0, "R8");                  // R8 jump to 0x0FFFFFFC
        step(0, 1, 32'h0C00_0010, 1, "R9");                  // R9 jal at region end
        step(0, 1, 32'h0BFF_FFFF, 1, "R8");                  // back to 0x0FFFFFFC
        step(0, 1, 32'h0000_0000, 0, "R3");                  // R3 crosses to 0x10000000
        step(0, 1, 32'h0800_0005, 0, "R8");                  // R8 upper bits kept = 1
        step(0, 1, 32'h1400_FFFE, 0, "R7");                  // R7 bne backward
        step(0, 1, 32'h1000_8000, 1, "R10");                 // R10 largest negative offset
        step(0, 0, 32'h0C00_0001, 1, "R2");                  // R2 stall on jal
        step(0, 1, 32'h3C00_0001, 1, "R12");                 // R12 advance
        step(1, 1, 32'h1000_0001, 1, "R1");
        step(0, 1, 32'h0000_0000, 1, "R1");                  // R1 pc zero after reset
        step(0, 1, 32'h0000_0000, 0, "R12");
        repeat (3) @(negedge clk);
        #5;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule